// File: doc/BRIEF.md
# Serial Gain Write Sequencer

This block sits in the host logic next to a variable-gain line driver. It takes a one-cycle parallel request that carries an 8-bit gain code and a two-bit command. It turns the request into a three-wire serial write and also drives the amplifier's enable line. The serial wires are an active-low transfer enable (`xfer_en`), a gated serial clock (`ser_clk`) and a data line (`ser_data`). The enable falls to open a write. Exactly eight clock pulses then carry the code, most significant bit first. The enable rises again to apply the new gain. Outside those eight pulses the serial clock stays low, so no clock energy couples into the analog output.

Every spacing on the serial lines is a whole number of system-clock cycles set by a parameter. The parameters cover clock high time, clock low time, enable-to-first-edge setup, last-edge-to-enable hold, gain settle after the apply edge, and output settle after wake-up. With a 100 MHz system clock the defaults give a 40 ns serial period with 20 ns high. They also give 20 ns of data and enable setup, at least 10 ns of hold, 30 ns of gain settle and 50 ns of wake settle.

There are three commands. A sleep command drops the amplifier enable (`amp_on`) without touching the serial wires. A wake command holds `amp_on` low, loads the gain, waits for it to settle and only then raises `amp_on`. The controller is built around the state machine IDLE, LEAD, HIGH, LOW, TAIL, APPLY, WAKE and FIN. The transitions are:
- IDLE→LEAD when a write or wake request is accepted.
- IDLE→FIN when a sleep request is accepted.
- LEAD→HIGH when the setup delay ends.
- HIGH→LOW between bits.
- HIGH→TAIL after the eighth bit.
- LOW→HIGH when the low time ends.
- TAIL→APPLY when the hold delay ends.
- APPLY→WAKE for wake commands, or APPLY→FIN for writes, when the gain settle ends.
- WAKE→FIN when the output settle ends.
- FIN→IDLE always.

Top module: `gain_wr_seq`

## Requirements
- R1: After reset, `xfer_en` is 1, `ser_clk` is 0, `ser_data` is 0, `amp_on` is 0, `busy` is 0 and `done` is 0.
- R2: A write command (`req_op` = 2'b00) makes `xfer_en` fall one cycle after acceptance. It then gives exactly eight `ser_clk` pulses, and `ser_data` sampled at the rising edges equals `req_gain`, most significant bit first. `xfer_en` then rises.
- R3: `ser_clk` is never high while `xfer_en` is high.
- R4: Each `ser_clk` high phase lasts CLK_HI cycles and each low phase between pulses lasts CLK_LO cycles. The first rising edge comes EN_SETUP cycles after `xfer_en` falls. `xfer_en` rises EN_HOLD cycles after the last falling edge.
- R5: `ser_data` never changes while `ser_clk` stays high.
- R6: `done` is a single-cycle pulse. For a write it comes GAIN_SETTLE cycles after `xfer_en` rises. `busy` is high from the cycle after acceptance through the `done` cycle and low in the cycle after it.
- R7: A wake command (`req_op` = 2'b10) drives `amp_on` low in the cycle after acceptance and loads the code as in R2. It raises `amp_on` GAIN_SETTLE cycles after `xfer_en` rises, and pulses `done` PD_SETTLE cycles after that.
- R8: A sleep command (`req_op` = 2'b01) drives `amp_on` low and pulses `done` in the cycle after acceptance, with no activity on `xfer_en` or `ser_clk`. A write command leaves `amp_on` unchanged.
- R9: A request presented while `busy` is high is ignored.
- R10: The command code 2'b11 is ignored: `busy` stays low, the serial lines stay idle and `amp_on` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | Command: 00 write, 01 sleep, 10 wake with gain load, 11 none |
| req_gain | input | WORD_W | Gain code to send |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| xfer_en | output | 1 | Active-low serial transfer enable; its rising edge applies the gain |
| ser_clk | output | 1 | Gated serial clock, eight pulses per write |
| ser_data | output | 1 | Serial gain data, MSB first |
| amp_on | output | 1 | Amplifier enable (low = powered down) |

## Verification
All outputs come from registers loaded from the next state, so each one changes at the clock edge that enters the state it reflects. `xfer_en` falls and `busy` rises exactly one cycle after the accepting edge. Every later edge is a fixed state duration after the one before it: EN_SETUP, then CLK_HI and CLK_LO alternating, then EN_HOLD, GAIN_SETTLE and, for a wake, PD_SETTLE. The bench samples every output on the falling system-clock edge and stamps each transition with a cycle count. It then checks the differences between those stamps against the parameter values, rather than polling for eventual outcomes. It sweeps all 256 gain codes and runs the wake, sleep, ignored-command and request-while-busy cases.

// File: rtl/gws_pkg.sv
package gws_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SLEEP = 2'b01,
        OP_WAKE  = 2'b10,
        OP_NONE  = 2'b11
    } gws_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_HIGH,
        S_LOW,
        S_TAIL,
        S_APPLY,
        S_WAKE,
        S_FIN
    } gws_state_e;

    function automatic int gws_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gws_delay.sv
module gws_delay #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/gws_sreg.sv
module gws_sreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         shift_i,
    output logic         bit_o,
    output logic         last_o
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= din_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[W-1];
    assign last_o = (idx_q == IW'(W - 1));

    // R2
    no_extra_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o);

endmodule

// File: rtl/gain_wr_seq.sv
module gain_wr_seq
    import gws_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int CLK_HI      = 2,
    parameter int CLK_LO      = 2,
    parameter int EN_SETUP    = 2,
    parameter int EN_HOLD     = 1,
    parameter int GAIN_SETTLE = 3,
    parameter int PD_SETTLE   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_gain,
    output logic              busy,
    output logic              done,
    output logic              xfer_en,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              amp_on
);

    localparam int DLY_MAX = gws_max(gws_max(gws_max(CLK_HI, CLK_LO), gws_max(EN_SETUP, EN_HOLD)),
                                     gws_max(GAIN_SETTLE, PD_SETTLE));
    localparam int TW = (DLY_MAX > 1) ? $clog2(DLY_MAX) : 1;

    gws_state_e    state_q, state_d;
    logic          wake_q;
    logic          amp_q;
    logic          busy_q, done_q, xfer_en_q, ser_clk_q;
    logic          accept, op_load, op_sleep;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sr_shift, sr_bit, sr_last;

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign op_load  = accept && ((req_op == OP_WRITE) || (req_op == OP_WAKE));
    assign op_sleep = accept && (req_op == OP_SLEEP);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (op_load) state_d = S_LEAD;
                     else if (op_sleep) state_d = S_FIN;
            S_LEAD:  if (tmr_zero) state_d = S_HIGH;
            S_HIGH:  if (tmr_zero) state_d = sr_last ? S_TAIL : S_LOW;
            S_LOW:   if (tmr_zero) state_d = S_HIGH;
            S_TAIL:  if (tmr_zero) state_d = S_APPLY;
            S_APPLY: if (tmr_zero) state_d = wake_q ? S_WAKE : S_FIN;
            S_WAKE:  if (tmr_zero) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // phase timer reload on every state change
    assign tmr_load = (state_d != state_q);
    always_comb begin
        unique case (state_d)
            S_LEAD:  tmr_val = TW'(EN_SETUP - 1);
            S_HIGH:  tmr_val = TW'(CLK_HI - 1);
            S_LOW:   tmr_val = TW'(CLK_LO - 1);
            S_TAIL:  tmr_val = TW'(EN_HOLD - 1);
            S_APPLY: tmr_val = TW'(GAIN_SETTLE - 1);
            S_WAKE:  tmr_val = TW'(PD_SETTLE - 1);
            default: tmr_val = '0;
        endcase
    end

    gws_delay #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    // data advances on the same edge that drops the serial clock
    assign sr_shift = (state_q == S_HIGH) && (state_d == S_LOW);

    gws_sreg #(.W(WORD_W)) u_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (op_load),
        .din_i   (req_gain),
        .shift_i (sr_shift),
        .bit_o   (sr_bit),
        .last_o  (sr_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wake_q  <= 1'b0;
            amp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wake_q <= (req_op == OP_WAKE);
            end
            if (op_sleep || (op_load && (req_op == OP_WAKE))) begin
                amp_q <= 1'b0;
            end else if ((state_q == S_APPLY) && (state_d == S_WAKE)) begin
                amp_q <= 1'b1;
            end
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            xfer_en_q <= 1'b1;
            ser_clk_q <= 1'b0;
        end else begin
            busy_q    <= (state_d != S_IDLE);
            done_q    <= (state_d == S_FIN);
            xfer_en_q <= !((state_d == S_LEAD) || (state_d == S_HIGH) ||
                           (state_d == S_LOW)  || (state_d == S_TAIL));
            ser_clk_q <= (state_d == S_HIGH);
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign xfer_en  = xfer_en_q;
    assign ser_clk  = ser_clk_q;
    assign ser_data = sr_bit & ~xfer_en_q;
    assign amp_on   = amp_q;

    // R3
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_q |-> !xfer_en_q);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_q && $past(ser_clk_q)) |-> $stable(ser_data));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_q) |-> (xfer_en_q && busy_q));

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_en_q) |-> !$past(busy_q));

endmodule

// File: tb/gain_wr_seq_tb.sv
module gain_wr_seq_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int WORD_W      = 8;
    localparam int CLK_HI      = 2;
    localparam int CLK_LO      = 2;
    localparam int EN_SETUP    = 2;
    localparam int EN_HOLD     = 1;
    localparam int GAIN_SETTLE = 3;
    localparam int PD_SETTLE   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [WORD_W-1:0] req_gain = '0;
    logic busy, done, xfer_en, ser_clk, ser_data, amp_on;

    int checks = 0;
    int fails  = 0;
    logic exp_amp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_wr_seq #(
        .WORD_W(WORD_W), .CLK_HI(CLK_HI), .CLK_LO(CLK_LO), .EN_SETUP(EN_SETUP),
        .EN_HOLD(EN_HOLD), .GAIN_SETTLE(GAIN_SETTLE), .PD_SETTLE(PD_SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_gain(req_gain), .busy(busy), .done(done), .xfer_en(xfer_en),
        .ser_clk(ser_clk), .ser_data(ser_data), .amp_on(amp_on)
    );

    // monitor state, owned by the monitor process only
    int epoch = 0;
    int seen = 0;
    int cyc = 0;
    int t_req, t_en_fall, t_en_rise, t_done, t_amp_rise, t_amp_fall;
    int npulse, nfall, ndone, nbusy, bad_data, bad_idle, bad_done;
    int rise_t[16];
    int fall_t[16];
    logic [WORD_W-1:0] word;
    logic busy_first, amp_first, busy_at_done, busy_after;
    logic prev_en = 1'b1, prev_clk = 1'b0, prev_data = 1'b0, prev_done = 1'b0, prev_amp = 1'b0;

    always @(negedge clk) begin
        if (epoch != seen) begin
            seen = epoch;
            t_req = -1; t_en_fall = -1; t_en_rise = -1; t_done = -1;
            t_amp_rise = -1; t_amp_fall = -1;
            npulse = 0; nfall = 0; ndone = 0; nbusy = 0;
            bad_data = 0; bad_idle = 0; bad_done = 0;
            word = '0; busy_first = 1'b0; amp_first = 1'b0;
            busy_at_done = 1'b0; busy_after = 1'b1;
        end
        cyc++;
        if (req_valid && t_req < 0) t_req = cyc;
        if (t_req >= 0 && cyc == t_req + 1) begin
            busy_first = busy;
            amp_first  = amp_on;
        end
        if (busy) nbusy++;
        if (prev_en && !xfer_en) t_en_fall = cyc;
        if (!prev_en && xfer_en) t_en_rise = cyc;
        if (!prev_clk && ser_clk) begin
            if (npulse < 16) rise_t[npulse] = cyc;
            word = {word[WORD_W-2:0], ser_data};
            npulse++;
        end
        if (prev_clk && !ser_clk) begin
            if (nfall < 16) fall_t[nfall] = cyc;
            nfall++;
        end
        if (ser_clk && prev_clk && (ser_data != prev_data)) bad_data++;
        if (ser_clk && xfer_en) bad_idle++;
        if (prev_done) busy_after = busy;
        if (done) begin
            if (prev_done) bad_done++;
            ndone++;
            t_done = cyc;
            busy_at_done = busy;
        end
        if (!prev_amp && amp_on) t_amp_rise = cyc;
        if (prev_amp && !amp_on) t_amp_fall = cyc;
        prev_en = xfer_en; prev_clk = ser_clk; prev_data = ser_data;
        prev_done = done; prev_amp = amp_on;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [WORD_W-1:0] g, input bit inject, input int max_wait);
        @(posedge clk); #1 epoch++;
        #1 req_valid = 1'b1; req_op = op; req_gain = g;
        @(posedge clk); #2 req_valid = 1'b0; req_op = 2'b00; req_gain = '0;
        if (inject) begin
            repeat (5) @(posedge clk);
            #2 req_valid = 1'b1; req_op = 2'b01; req_gain = '1;
            repeat (4) @(posedge clk);
            #2 req_valid = 1'b0; req_op = 2'b00; req_gain = '0;
        end
        for (int n = 0; n < max_wait && ndone == 0; n++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // serial frame checks shared by write and wake
    task automatic check_frame(input logic [WORD_W-1:0] g);
        chk(t_en_fall == t_req + 1, "R2 enable fall", t_en_fall - t_req, 1);
        chk(npulse == 8 && nfall == 8, "R2 pulse count", npulse, 8);
        chk(word == g, "R2 word", int'(word), int'(g));
        chk(t_en_rise > 0, "R2 enable rise", t_en_rise, 1);
        chk(bad_idle == 0, "R3 clock while idle", bad_idle, 0);
        chk(rise_t[0] - t_en_fall == EN_SETUP, "R4 setup", rise_t[0] - t_en_fall, EN_SETUP);
        for (int i = 0; i < 8; i++) begin
            chk(fall_t[i] - rise_t[i] == CLK_HI, "R4 high time", fall_t[i] - rise_t[i], CLK_HI);
            if (i > 0) chk(rise_t[i] - fall_t[i-1] == CLK_LO, "R4 low time", rise_t[i] - fall_t[i-1], CLK_LO);
        end
        chk(t_en_rise - fall_t[7] == EN_HOLD, "R4 hold", t_en_rise - fall_t[7], EN_HOLD);
        chk(bad_data == 0, "R5 data change in high phase", bad_data, 0);
        chk(ndone == 1 && bad_done == 0, "R6 done pulses", ndone, 1);
        chk(busy_first == 1'b1, "R6 busy after accept", busy_first, 1);
        chk(busy_at_done == 1'b1 && busy_after == 1'b0, "R6 busy at and after done", busy_after, 0);
    endtask

    task automatic do_write(input logic [WORD_W-1:0] g, input bit inject);
        run_op(2'b00, g, inject, 400);
        check_frame(g);
        chk(t_done - t_en_rise == GAIN_SETTLE, "R6 gain settle", t_done - t_en_rise, GAIN_SETTLE);
        chk(amp_on == exp_amp, "R8 write keeps amp_on", amp_on, exp_amp);
        if (inject) chk(t_amp_fall < 0, "R9 sleep while busy ignored", t_amp_fall, -1);
    endtask

    task automatic do_wake(input logic [WORD_W-1:0] g);
        run_op(2'b10, g, 1'b0, 400);
        check_frame(g);
        chk(amp_first == 1'b0, "R7 amp_on low after accept", amp_first, 0);
        chk(t_amp_rise - t_en_rise == GAIN_SETTLE, "R7 amp rise after apply", t_amp_rise - t_en_rise, GAIN_SETTLE);
        chk(t_done - t_amp_rise == PD_SETTLE, "R7 output settle", t_done - t_amp_rise, PD_SETTLE);
        exp_amp = 1'b1;
        chk(amp_on == 1'b1, "R7 amp_on after wake", amp_on, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(xfer_en == 1'b1, "R1 xfer_en", xfer_en, 1);
        chk(ser_clk == 1'b0, "R1 ser_clk", ser_clk, 0);
        chk(ser_data == 1'b0, "R1 ser_data", ser_data, 0);
        chk(amp_on == 1'b0, "R1 amp_on", amp_on, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", busy, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5 R6: full code sweep
        for (int g = 0; g < 256; g++) do_write(WORD_W'(g), 1'b0);

        // R7 wake from sleep
        do_wake(8'hA5);
        do_write(8'h5A, 1'b0);

        // R9 request while busy
        do_write(8'h3C, 1'b1);

        // R8 sleep
        run_op(2'b01, 8'hFF, 1'b0, 50);
        chk(t_amp_fall == t_req + 1, "R8 amp_on fall", t_amp_fall - t_req, 1);
        chk(t_done == t_req + 1 && ndone == 1, "R8 done timing", t_done - t_req, 1);
        chk(t_en_fall < 0 && npulse == 0, "R8 serial idle", npulse, 0);
        exp_amp = 1'b0;

        // R10 unused command
        run_op(2'b11, 8'h81, 1'b0, 20);
        chk(nbusy == 0 && ndone == 0, "R10 no busy", nbusy, 0);
        chk(t_en_fall < 0 && npulse == 0, "R10 serial idle", npulse, 0);
        chk(amp_on == exp_amp, "R10 amp_on kept", amp_on, exp_amp);

        do_wake(8'hFF);
        do_wake(8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule